// File: doc/BRIEF.md
# Event Status and Interrupt Mask Unit

This block collects the event pulses of a serial memory controller into sticky flags and turns them into one level interrupt request. Seven events are tracked: receive data full, transmit data empty, transmitter empty, overrun, chip-select rise, chip-select fall and instruction end. A status read returns the flags together with the controller-enabled level. The read also clears the flags, so software sees each event once.

The interrupt mask has no direct write port. A write-one-to-set enable strobe adds mask bits, and a write-one-to-clear disable strobe removes them. The current mask can be read at any time. The request output is high while any flagged event is also unmasked.

A separate command-complete output is high once both instruction end and chip-select rise have been flagged. Software uses it to tell that a whole frame, including the chip-select release, has finished.

Top module: `sts_irq_unit`

## Requirements
- R1: After reset all event flags and all mask bits are zero, `irq_o` is low and `cmd_done_o` is low.
- R2: A one-cycle pulse on an `ev_i` bit sets its flag at the next clock edge. The flags appear on `sts_o` at these bits: `ev_i[0]` (receive full) at bit 0, `ev_i[1]` (transmit empty) at bit 1, `ev_i[2]` (transmitter empty) at bit 2, `ev_i[3]` (overrun) at bit 3, `ev_i[4]` (chip-select rise) at bit 8, `ev_i[5]` (chip-select fall) at bit 9 and `ev_i[6]` (instruction end) at bit 10.
- R3: A cycle with `sts_rd_i` high clears every event flag at the next edge. `sts_o` shows the flags unchanged during that read cycle.
- R4: An event that arrives in the same cycle as a status read leaves its flag set after the read.
- R5: A flag stays set for any number of cycles until a status read clears it.
- R6: When `ien_we_i` is high, each one in `ien_wdata_i` at an event bit position sets that mask bit at the next edge. Other mask bits are unchanged.
- R7: When `idis_we_i` is high, each one in `idis_wdata_i` at an event bit position clears that mask bit at the next edge. If the enable and disable strobes hit the same bit together, the bit ends up clear.
- R8: `mask_o` carries the mask at the same bit positions as the status flags. Every other bit of `mask_o`, including bit 24, reads zero.
- R9: `irq_o` is high exactly when some event flag and its mask bit are both set. It is a level and falls after the clearing read or the disable write.
- R10: `cmd_done_o` is high exactly when both the instruction-end flag (bit 10) and the chip-select-rise flag (bit 8) are set.
- R11: `sts_o` bit 24 follows `enabled_i` in the same cycle. A status read does not clear it. All unused status bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ev_i | input | 7 | Event pulses from the serial engine |
| enabled_i | input | 1 | Controller-enabled level |
| sts_rd_i | input | 1 | Status read strobe, clears the flags |
| ien_we_i | input | 1 | Mask enable write strobe |
| ien_wdata_i | input | 32 | Mask enable data, write one to set |
| idis_we_i | input | 1 | Mask disable write strobe |
| idis_wdata_i | input | 32 | Mask disable data, write one to clear |
| sts_o | output | 32 | Status word |
| mask_o | output | 32 | Current interrupt mask |
| irq_o | output | 1 | Level interrupt request |
| cmd_done_o | output | 1 | Instruction end and chip-select rise both flagged |

## Verification
A flag that is lost or stuck shows up on `sts_o` in the cycle after the event or after the read. A mask bit with the wrong value shows on `mask_o` one cycle after the write, and `irq_o` follows it combinationally. The most delicate case is an event that lands in a read cycle. If it is dropped, the only sign is a missing bit on the next status word, so the bench reads back straight after that collision. The disable-wins rule is exercised both from a clear mask bit and from a set one.

// File: rtl/sts_irq_pkg.sv
package sts_irq_pkg;
  localparam int DW      = 32;
  localparam int NUM_EV  = 7;
  localparam int EN_POS  = 24;
  localparam int IDX_CSR = 4;
  localparam int IDX_INS = 6;

  // status bit of each event index; software decodes these positions
  function automatic int ev_pos(input int idx);
    case (idx)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 3;
      4: return 8;
      5: return 9;
      6: return 10;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/sts_flag_bank.sv
module sts_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  // a new event wins over the clear so nothing is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (clr_i ? '0 : flags_q) | ev_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/sts_mask_reg.sv
module sts_mask_reg #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;

  // clear applied last: disable wins a collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q | set_i) & ~clr_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/sts_irq_combine.sv
module sts_irq_combine #(
  parameter int N       = 7,
  parameter int IDX_A   = 6,
  parameter int IDX_B   = 4
) (
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o,
  output logic         done_o
);
  assign irq_o  = |(flags_i & mask_i);
  assign done_o = flags_i[IDX_A] & flags_i[IDX_B];
endmodule

// File: rtl/sts_irq_unit.sv
module sts_irq_unit
  import sts_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              enabled_i,
  input  logic              sts_rd_i,
  input  logic              ien_we_i,
  input  logic [DW-1:0]     ien_wdata_i,
  input  logic              idis_we_i,
  input  logic [DW-1:0]     idis_wdata_i,
  output logic [DW-1:0]     sts_o,
  output logic [DW-1:0]     mask_o,
  output logic              irq_o,
  output logic              cmd_done_o
);
  logic [NUM_EV-1:0] flags;
  logic [NUM_EV-1:0] mask;
  logic [NUM_EV-1:0] mset;
  logic [NUM_EV-1:0] mclr;
  logic [DW-1:0]     ev_word;
  logic [DW-1:0]     msk_word;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_map
    localparam int P = ev_pos(i);
    assign mset[i] = ien_we_i  & ien_wdata_i[P];
    assign mclr[i] = idis_we_i & idis_wdata_i[P];
  end

  always_comb begin
    ev_word  = '0;
    msk_word = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      ev_word[ev_pos(i)]  = flags[i];
      msk_word[ev_pos(i)] = mask[i];
    end
    ev_word[EN_POS] = enabled_i;
  end

  sts_flag_bank #(.N(NUM_EV)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev_i),
    .clr_i   (sts_rd_i),
    .flags_o (flags)
  );

  sts_mask_reg #(.N(NUM_EV)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (mset),
    .clr_i  (mclr),
    .mask_o (mask)
  );

  sts_irq_combine #(.N(NUM_EV), .IDX_A(IDX_INS), .IDX_B(IDX_CSR)) u_comb (
    .flags_i (flags),
    .mask_i  (mask),
    .irq_o   (irq_o),
    .done_o  (cmd_done_o)
  );

  assign sts_o  = ev_word;
  assign mask_o = msk_word;
endmodule

// File: rtl/sts_irq_unit_chk.sv
module sts_irq_unit_chk
  import sts_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_EV-1:0] ev_i,
  input logic              enabled_i,
  input logic              sts_rd_i,
  input logic              ien_we_i,
  input logic [DW-1:0]     ien_wdata_i,
  input logic              idis_we_i,
  input logic [DW-1:0]     idis_wdata_i,
  input logic [DW-1:0]     sts_o,
  input logic [DW-1:0]     mask_o,
  input logic              irq_o,
  input logic              cmd_done_o
);
  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    localparam int P = ev_pos(i);

    a_r2_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[i] |=> sts_o[P]);
    a_r3_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_rd_i && !ev_i[i]) |=> !sts_o[P]);
    a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sts_rd_i && sts_o[P]) |=> sts_o[P]);
    a_r6_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ien_we_i && ien_wdata_i[P] && !(idis_we_i && idis_wdata_i[P])) |=> mask_o[P]);
    a_r7_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (idis_we_i && idis_wdata_i[P]) |=> !mask_o[P]);
  end

  a_r9_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(sts_o & mask_o));
  a_r10_cmd_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_o == (sts_o[ev_pos(IDX_INS)] && sts_o[ev_pos(IDX_CSR)]));
  a_r8_mask_unused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_o[EN_POS] == 1'b0);
  a_r11_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o[EN_POS] == enabled_i);
endmodule

bind sts_irq_unit sts_irq_unit_chk u_chk (.*);

// File: tb/sts_irq_unit_tb.sv
module sts_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  ev_i = '0;
  logic        enabled_i = 1'b0;
  logic        sts_rd_i = 1'b0;
  logic        ien_we_i = 1'b0;
  logic [31:0] ien_wdata_i = '0;
  logic        idis_we_i = 1'b0;
  logic [31:0] idis_wdata_i = '0;
  logic [31:0] sts_o;
  logic [31:0] mask_o;
  logic        irq_o;
  logic        cmd_done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sts_irq_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ev_i(ev_i), .enabled_i(enabled_i),
    .sts_rd_i(sts_rd_i), .ien_we_i(ien_we_i), .ien_wdata_i(ien_wdata_i),
    .idis_we_i(idis_we_i), .idis_wdata_i(idis_wdata_i), .sts_o(sts_o),
    .mask_o(mask_o), .irq_o(irq_o), .cmd_done_o(cmd_done_o)
  );

  function automatic int pos_of(input int i);
    int t[7] = '{0, 1, 2, 3, 8, 9, 10};
    return t[i];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse(input logic [6:0] e);
    ev_i = e;
    cyc();
    ev_i = '0;
  endtask

  task automatic rd();
    sts_rd_i = 1'b1;
    cyc();
    sts_rd_i = 1'b0;
  endtask

  task automatic wr_en(input logic [31:0] d);
    ien_we_i = 1'b1; ien_wdata_i = d;
    cyc();
    ien_we_i = 1'b0; ien_wdata_i = '0;
  endtask

  task automatic wr_dis(input logic [31:0] d);
    idis_we_i = 1'b1; idis_wdata_i = d;
    cyc();
    idis_we_i = 1'b0; idis_wdata_i = '0;
  endtask

  task automatic t_reset();
    chk("R1 sts", sts_o, 32'h0);
    chk("R1 mask", mask_o, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    chk("R1 done", {31'h0, cmd_done_o}, 32'h0);
  endtask

  task automatic t_capture();
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1 << i));
      chk("R2 flag position", sts_o, 32'h1 << pos_of(i));
      sts_rd_i = 1'b1;
      #1;
      chk("R3 read shows flags", sts_o, 32'h1 << pos_of(i));
      cyc();
      sts_rd_i = 1'b0;
      chk("R3 cleared after read", sts_o, 32'h0);
    end
    pulse(7'h7F);
    chk("R2 all flags", sts_o, 32'h0000_070F);
    rd();
    chk("R3 all cleared", sts_o, 32'h0);
  endtask

  task automatic t_sticky();
    pulse(7'b000_0001);
    cyc(); cyc(); cyc();
    chk("R5 flag held", sts_o, 32'h1);
    rd();
  endtask

  task automatic t_race();
    pulse(7'b000_0010);
    ev_i = 7'b000_1000;
    sts_rd_i = 1'b1;
    cyc();
    ev_i = '0;
    sts_rd_i = 1'b0;
    chk("R4 event during read kept", sts_o, 32'h8);
    rd();
    chk("R4 later read clears", sts_o, 32'h0);
  endtask

  task automatic t_mask();
    wr_en(32'h0100_0F2F);
    chk("R6 R8 mask set, unused zero", mask_o, 32'h0000_070F);
    wr_dis(32'h0000_0003);
    chk("R7 mask cleared", mask_o, 32'h0000_070C);
    wr_en(32'h0000_0003);
    chk("R6 other bits kept", mask_o, 32'h0000_070F);
    ien_we_i = 1'b1; ien_wdata_i = 32'h0000_0001;
    idis_we_i = 1'b1; idis_wdata_i = 32'h0000_0401;
    cyc();
    ien_we_i = 1'b0; idis_we_i = 1'b0; ien_wdata_i = '0; idis_wdata_i = '0;
    chk("R7 disable wins on set bit", mask_o, 32'h0000_030E);
    wr_dis(32'hFFFF_FFFF);
    ien_we_i = 1'b1; ien_wdata_i = 32'h0000_0004;
    idis_we_i = 1'b1; idis_wdata_i = 32'h0000_0004;
    cyc();
    ien_we_i = 1'b0; idis_we_i = 1'b0; ien_wdata_i = '0; idis_wdata_i = '0;
    chk("R7 disable wins on clear bit", mask_o, 32'h0);
  endtask

  task automatic t_irq();
    wr_en(32'h0000_0008);
    pulse(7'b000_0001);
    chk("R9 masked event no irq", {31'h0, irq_o}, 32'h0);
    pulse(7'b000_1000);
    chk("R9 unmasked event irq", {31'h0, irq_o}, 32'h1);
    cyc();
    chk("R9 irq level held", {31'h0, irq_o}, 32'h1);
    rd();
    chk("R9 irq falls after read", {31'h0, irq_o}, 32'h0);
    pulse(7'b000_1000);
    wr_dis(32'h0000_0008);
    chk("R9 irq falls after disable", {31'h0, irq_o}, 32'h0);
    rd();
  endtask

  task automatic t_done();
    pulse(7'b100_0000);
    chk("R10 instr end alone", {31'h0, cmd_done_o}, 32'h0);
    pulse(7'b001_0000);
    chk("R10 both flags", {31'h0, cmd_done_o}, 32'h1);
    rd();
    chk("R10 cleared by read", {31'h0, cmd_done_o}, 32'h0);
    pulse(7'b001_0000);
    chk("R10 cs rise alone", {31'h0, cmd_done_o}, 32'h0);
    rd();
    pulse(7'b101_0000);
    chk("R10 both at once", {31'h0, cmd_done_o}, 32'h1);
    rd();
  endtask

  task automatic t_enabled();
    enabled_i = 1'b1;
    #1;
    chk("R11 enabled bit", sts_o, 32'h0100_0000);
    rd();
    chk("R11 enabled not cleared", sts_o, 32'h0100_0000);
    wr_en(32'h0100_0000);
    chk("R8 bit 24 mask zero", mask_o, 32'h0);
    chk("R11 no irq from enabled", {31'h0, irq_o}, 32'h0);
    enabled_i = 1'b0;
    #1;
    chk("R11 enabled low", sts_o, 32'h0);
  endtask

  initial begin
    #20;
    rst_ni = 1'b1;
    cyc();
    t_reset();
    t_capture();
    t_sticky();
    t_race();
    t_mask();
    t_irq();
    t_done();
    t_enabled();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule